// File: doc/BRIEF.md
# Dark-Pixel Black-Level Restorer

This block sits in a camera's pixel pipeline directly after digitization. It accepts one sample per valid beat. Each sample carries a class tag that says whether it is a dummy transport position, a light-sensitive image pixel or a light-shielded dark pixel. A line-start marker flags the first beat of every line, and a frame-start marker may accompany it.

A line carries its shielded pixels at its tail. The block averages those dark samples to estimate the black level, keeps the result across the line boundary, and subtracts it from every image pixel of the following line. The first line of a frame has no earlier line to learn from, so it uses a programmable default level. Dummy, dark and reserved samples never reach the output. Image samples leave in their arrival order, with a fixed two-cycle latency. Line-start, frame-start and line-end markers are re-attached to the corrected image samples. A line whose shielded-pixel count is wrong leaves the stored level untouched and raises a sticky error.

Top module: `black_level_restorer`

## Requirements
- R1: Only samples tagged as image (class 2'b01) produce an output beat. Dummy (2'b00), dark (2'b10) and reserved (2'b11) samples never do.
- R2: Every valid image sample appears on the output exactly two clock cycles after the cycle in which it is presented. Output order equals input order.
- R3: At the start of a line without frame start, the level loaded is round(S/N) = floor((S + N/2)/N). Here S is the sum of the N dark samples of the preceding line, and N is DARK_PIX (12 by default). This level applies to every image sample of the new line, including one on the line-start beat itself.
- R4: At the start of a line flagged as frame start, the level loaded is the value on `defaultRef`, whatever the preceding line held.
- R5: Each output value is the image sample minus the active level. A negative result gives 0, and a result above 2^OW-1 gives 2^OW-1.
- R6: At a line start after the first one since reset, a preceding dark count other than DARK_PIX has two effects. The stored level is kept (unless the new line is a frame start), and `errSticky` goes high one cycle later and stays high until reset.
- R7: `outLineStart` marks the first image output of each line. `outFrameStart` marks the first image output of a line that began with frame start.
- R8: `outLineEnd` marks the IMG_PIX-th image output of a line.
- R9: After reset, `outValid`, all output markers and `errSticky` are low.
- R10: Beats with `inValid` low are ignored, including any class, data or markers they carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat qualifier |
| inData | input | DW | Digitized sample |
| inClass | input | 2 | Sample class: 00 dummy, 01 image, 10 dark, 11 reserved |
| inLineStart | input | 1 | First beat of a line |
| inFrameStart | input | 1 | With inLineStart, first line of a frame |
| defaultRef | input | DW | Black level used for a frame's first line |
| outValid | output | 1 | Corrected image sample present |
| outData | output | OW | Corrected, saturated image sample |
| outLineStart | output | 1 | First image output of a line |
| outFrameStart | output | 1 | First image output of a frame |
| outLineEnd | output | 1 | IMG_PIX-th image output of a line |
| errSticky | output | 1 | A line ended with the wrong dark count |

## Verification
The assertions take it that `inClass` and `inValid` are driven to known values every cycle. They also take it that `inFrameStart` matters only on a valid line-start beat, and that `defaultRef` is stable at the frame-start beat that loads it. The stimulus keeps inside these limits. Every input changes only on the falling clock edge. Valid-low gaps may carry line markers and image tags, but these are meant to be ignored. A frame start is always given together with a line start. Malformed lines differ only in their dark-pixel count, so every run of dummy, image and dark samples keeps its expected order.

// File: rtl/blr_pkg.sv
package blr_pkg;

  typedef enum logic [1:0] {
    PIX_DUMMY = 2'b00,
    PIX_IMAGE = 2'b01,
    PIX_DARK  = 2'b10,
    PIX_RSVD  = 2'b11
  } pixClass_e;

  // strobes from line control to the datapath, all valid for the current beat
  typedef struct packed {
    logic lineBegin;    // valid beat carrying a line start
    logic darkAdd;      // valid beat of a shielded sample
    logic loadAvg;      // capture the averaged dark level
    logic loadDefault;  // capture the programmable default level
    logic imgBeat;      // valid image sample to correct
    logic markLine;     // first image sample of the line
    logic markFrame;    // first image sample of the frame
    logic markEnd;      // last expected image sample of the line
  } blrStrobe_t;

endpackage

// File: rtl/blr_ctrl.sv
module blr_ctrl
  import blr_pkg::*;
#(
  parameter int DARK_PIX = 12,
  parameter int IMG_PIX  = 192
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inClass,
  input  logic       inLineStart,
  input  logic       inFrameStart,
  output blrStrobe_t st,
  output logic       errFlag
);

  localparam int CNT_W = $clog2(DARK_PIX + 2);
  localparam int IMG_W = $clog2(IMG_PIX + 1);
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(DARK_PIX);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(DARK_PIX + 1);
  localparam logic [IMG_W-1:0] IMG_LAST = IMG_W'(IMG_PIX - 1);
  localparam logic [IMG_W-1:0] IMG_SAT  = IMG_W'(IMG_PIX);

  logic [CNT_W-1:0] darkCnt;
  logic [IMG_W-1:0] imgCnt;
  logic [IMG_W-1:0] curImg;
  logic lineSeen;
  logic linePend;
  logic framePend;
  logic lineBegin;
  logic frameBegin;
  logic isImg;
  logic isDark;
  logic countOk;

  always_comb begin
    isImg      = (inClass == PIX_IMAGE);
    isDark     = (inClass == PIX_DARK);
    lineBegin  = inValid && inLineStart;
    frameBegin = lineBegin && inFrameStart;
    countOk    = (darkCnt == CNT_OK);
    curImg     = lineBegin ? '0 : imgCnt;

    st.lineBegin   = lineBegin;
    st.darkAdd     = inValid && isDark;
    st.loadDefault = frameBegin;
    st.loadAvg     = lineBegin && !frameBegin && lineSeen && countOk;
    st.imgBeat     = inValid && isImg;
    st.markLine    = st.imgBeat && (lineBegin || linePend);
    st.markFrame   = st.imgBeat && (frameBegin || (framePend && !lineBegin));
    st.markEnd     = st.imgBeat && (curImg == IMG_LAST);
  end

  // dark-pixel count of the running line, saturating one past the expected value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      darkCnt <= '0;
    end else if (lineBegin) begin
      darkCnt <= st.darkAdd ? CNT_W'(1) : '0;
    end else if (st.darkAdd && darkCnt != CNT_SAT) begin
      darkCnt <= darkCnt + 1'b1;
    end
  end

  // image-pixel position within the line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      imgCnt <= '0;
    end else if (lineBegin) begin
      imgCnt <= st.imgBeat ? IMG_W'(1) : '0;
    end else if (st.imgBeat && imgCnt != IMG_SAT) begin
      imgCnt <= imgCnt + 1'b1;
    end
  end

  // pending first-pixel markers and the error state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineSeen  <= 1'b0;
      linePend  <= 1'b0;
      framePend <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (lineBegin) begin
        lineSeen  <= 1'b1;
        linePend  <= !st.imgBeat;
        framePend <= frameBegin && !st.imgBeat;
      end else if (st.imgBeat) begin
        linePend  <= 1'b0;
        framePend <= 1'b0;
      end
      if (lineBegin && lineSeen && !countOk) begin
        errFlag <= 1'b1;
      end
    end
  end

  // R6: once raised, the error never drops without reset
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R6: a bad dark count at a line boundary reports
  assert_bad_count_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lineBegin && lineSeen && darkCnt != CNT_OK) |=> errFlag);

  // R7: a frame marker only ever rides with a line marker
  assert_frame_mark_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.markFrame |-> st.markLine);

endmodule

// File: rtl/blr_datapath.sv
module blr_datapath
  import blr_pkg::*;
#(
  parameter int DW       = 12,
  parameter int OW       = 12,
  parameter int DARK_PIX = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  blrStrobe_t    st,
  input  logic [DW-1:0] inData,
  input  logic [DW-1:0] defaultRef,
  output logic          outValid,
  output logic [OW-1:0] outData,
  output logic          outLineStart,
  output logic          outFrameStart,
  output logic          outLineEnd
);

  // sum of DARK_PIX samples, plus half the divisor for rounding
  localparam int SUM_W  = DW + $clog2(DARK_PIX);
  localparam int RND_W  = SUM_W + 1;
  // exact floor division by DARK_PIX for any RND_W-bit value
  localparam int REC_SH = RND_W + $clog2(DARK_PIX);
  localparam int PROD_W = RND_W + REC_SH + 1;
  localparam logic [63:0] RECIP =
    ((64'd1 << REC_SH) + 64'(DARK_PIX) - 64'd1) / 64'(DARK_PIX);
  localparam logic [RND_W-1:0] HALF = RND_W'(DARK_PIX / 2);
  localparam logic [DW-1:0] OUT_MAX = DW'((64'd1 << OW) - 64'd1);

  logic [SUM_W-1:0]  darkSum;
  logic [RND_W-1:0]  rounded;
  logic [PROD_W-1:0] prod;
  logic [DW-1:0]     avgRef;
  logic [DW-1:0]     refReg;

  logic          s1Valid;
  logic [DW-1:0] s1Data;
  logic          s1Line;
  logic          s1Frame;
  logic          s1End;

  logic [DW:0]   diff;
  logic [OW-1:0] clamped;

  // running dark sum of the current line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      darkSum <= '0;
    end else if (st.lineBegin) begin
      darkSum <= st.darkAdd ? SUM_W'(inData) : '0;
    end else if (st.darkAdd) begin
      darkSum <= darkSum + SUM_W'(inData);
    end
  end

  // rounded mean via reciprocal multiply
  always_comb begin
    rounded = RND_W'(darkSum) + HALF;
    prod    = PROD_W'(rounded) * PROD_W'(RECIP);
    avgRef  = DW'(prod >> REC_SH);
  end

  // black level carried across the line boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refReg <= '0;
    end else if (st.loadDefault) begin
      refReg <= defaultRef;
    end else if (st.loadAvg) begin
      refReg <= avgRef;
    end
  end

  // stage 1: capture the image sample and its markers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Data  <= '0;
      s1Line  <= 1'b0;
      s1Frame <= 1'b0;
      s1End   <= 1'b0;
    end else begin
      s1Valid <= st.imgBeat;
      s1Data  <= inData;
      s1Line  <= st.markLine;
      s1Frame <= st.markFrame;
      s1End   <= st.markEnd;
    end
  end

  // subtract and saturate against the level now in force
  always_comb begin
    diff = {1'b0, s1Data} - {1'b0, refReg};
    if (diff[DW]) begin
      clamped = '0;
    end else if (diff[DW-1:0] > OUT_MAX) begin
      clamped = OW'(OUT_MAX);
    end else begin
      clamped = OW'(diff[DW-1:0]);
    end
  end

  // stage 2: output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outData       <= '0;
      outLineStart  <= 1'b0;
      outFrameStart <= 1'b0;
      outLineEnd    <= 1'b0;
    end else begin
      outValid      <= s1Valid;
      outData       <= s1Valid ? clamped : '0;
      outLineStart  <= s1Valid && s1Line;
      outFrameStart <= s1Valid && s1Frame;
      outLineEnd    <= s1Valid && s1End;
    end
  end

  // R6: the level only moves on a load strobe
  assert_ref_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!st.loadAvg && !st.loadDefault) |=> $stable(refReg));

  // R4: a frame start installs the default level
  assert_default_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    st.loadDefault |=> (refReg == $past(defaultRef)));

  // R5: a sample at or below the level comes out as zero
  assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && s1Data <= refReg) |=> (outValid && outData == '0));

endmodule

// File: rtl/black_level_restorer.sv
module black_level_restorer
  import blr_pkg::*;
#(
  parameter int DW       = 12,
  parameter int OW       = 12,
  parameter int DARK_PIX = 12,
  parameter int IMG_PIX  = 192
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [DW-1:0] inData,
  input  logic [1:0]    inClass,
  input  logic          inLineStart,
  input  logic          inFrameStart,
  input  logic [DW-1:0] defaultRef,
  output logic          outValid,
  output logic [OW-1:0] outData,
  output logic          outLineStart,
  output logic          outFrameStart,
  output logic          outLineEnd,
  output logic          errSticky
);

  blrStrobe_t st;

  blr_ctrl #(
    .DARK_PIX(DARK_PIX),
    .IMG_PIX (IMG_PIX)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inClass     (inClass),
    .inLineStart (inLineStart),
    .inFrameStart(inFrameStart),
    .st          (st),
    .errFlag     (errSticky)
  );

  blr_datapath #(
    .DW      (DW),
    .OW      (OW),
    .DARK_PIX(DARK_PIX)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .inData       (inData),
    .defaultRef   (defaultRef),
    .outValid     (outValid),
    .outData      (outData),
    .outLineStart (outLineStart),
    .outFrameStart(outFrameStart),
    .outLineEnd   (outLineEnd)
  );

  // R1: anything but a valid image beat leaves no output two cycles on
  assert_discard_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inClass == PIX_IMAGE) |-> ##2 !outValid);

  // R2: a valid image beat always emerges two cycles on
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inClass == PIX_IMAGE) |-> ##2 outValid);

  // R7: markers only accompany a corrected sample
  assert_marker_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outLineStart || outFrameStart || outLineEnd) |-> outValid);

endmodule

// File: tb/tb_black_level_restorer.sv
module tb_black_level_restorer;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int OW = 7;
  localparam int DARK_PIX = 12;
  localparam int IMG_PIX = 16;
  localparam int OUT_MAX = (1 << OW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic [1:0]    inClass = 2'b00;
  logic          inLineStart = 1'b0;
  logic          inFrameStart = 1'b0;
  logic [DW-1:0] defaultRef = '0;
  logic          outValid;
  logic [OW-1:0] outData;
  logic          outLineStart;
  logic          outFrameStart;
  logic          outLineEnd;
  logic          errSticky;

  always #(CLK_PERIOD / 2) clk = ~clk;

  black_level_restorer #(
    .DW(DW), .OW(OW), .DARK_PIX(DARK_PIX), .IMG_PIX(IMG_PIX)
  ) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inClass(inClass), .inLineStart(inLineStart), .inFrameStart(inFrameStart),
    .defaultRef(defaultRef), .outValid(outValid), .outData(outData),
    .outLineStart(outLineStart), .outFrameStart(outFrameStart),
    .outLineEnd(outLineEnd), .errSticky(errSticky)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // requirement model state
  int  refM = 0;
  int  darkSumM = 0;
  int  darkCntM = 0;
  bit  lineSeenM = 0;
  bit  errM = 0;
  bit  linePendM = 0;
  bit  framePendM = 0;
  int  imgCntM = 0;
  bit  firstOfFrameM = 0;
  int  gapCtr = 0;

  // two-entry expected pipeline, index 1 is due at the output now
  bit    expV[2];
  int    expD[2];
  bit    expL[2];
  bit    expF[2];
  bit    expE[2];
  string tagV[2];
  string tagD[2];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic beat(input bit v, input logic [1:0] cls, input int data,
                      input bit ls, input bit fs);
    int val;
    @(negedge clk);
    // compare what is due now
    check(outValid == expV[1], tagV[1], int'(outValid), int'(expV[1]));
    if (expV[1]) begin
      check(int'(outData) == expD[1], tagD[1], int'(outData), expD[1]);
      check(outLineStart == expL[1], "R7 line marker", int'(outLineStart), int'(expL[1]));
      check(outFrameStart == expF[1], "R7 frame marker", int'(outFrameStart), int'(expF[1]));
      check(outLineEnd == expE[1], "R8 line end", int'(outLineEnd), int'(expE[1]));
    end
    check(errSticky == errM, "R6 error flag", int'(errSticky), int'(errM));
    expV[1] = expV[0]; expD[1] = expD[0]; expL[1] = expL[0];
    expF[1] = expF[0]; expE[1] = expE[0]; tagV[1] = tagV[0]; tagD[1] = tagD[0];
    // model the new beat
    expV[0] = 0; expD[0] = 0; expL[0] = 0; expF[0] = 0; expE[0] = 0;
    tagV[0] = v ? "R1 non-image discarded" : "R10 invalid beat ignored";
    tagD[0] = "R3";
    if (v && ls) begin
      if (lineSeenM && darkCntM != DARK_PIX) errM = 1;
      if (fs) refM = int'(defaultRef);
      else if (lineSeenM && darkCntM == DARK_PIX) refM = (darkSumM + DARK_PIX / 2) / DARK_PIX;
      firstOfFrameM = fs;
      lineSeenM = 1; darkSumM = 0; darkCntM = 0; imgCntM = 0;
      linePendM = 1; framePendM = fs;
    end
    if (v && cls == 2'b01) begin
      val = data - refM;
      tagD[0] = firstOfFrameM ? "R4 default level" : "R3 dark average";
      if (val < 0) begin val = 0; tagD[0] = "R5 low saturation"; end
      if (val > OUT_MAX) begin val = OUT_MAX; tagD[0] = "R5 high saturation"; end
      expV[0] = 1; expD[0] = val; expL[0] = linePendM; expF[0] = framePendM;
      imgCntM++;
      expE[0] = (imgCntM == IMG_PIX);
      linePendM = 0; framePendM = 0;
      tagV[0] = "R2 latency";
    end
    if (v && cls == 2'b10) begin
      darkSumM += data; darkCntM++;
    end
    inValid = v; inClass = cls; inData = DW'(data);
    inLineStart = ls; inFrameStart = fs;
  endtask

  task automatic gapMaybe();
    gapCtr++;
    if (gapCtr % 5 == 0) beat(1'b0, 2'b01, 250, 1'b1, 1'b1);
  endtask

  task automatic sendLine(input bit fs, input int nDummy, input int lineIdx,
                          input int nDark, input int darkBase, input int darkBump);
    bit first = 1'b1;
    for (int i = 0; i < nDummy; i++) begin
      beat(1'b1, (i == 2) ? 2'b11 : 2'b00, 255 - i, first, first && fs);
      first = 1'b0;
      gapMaybe();
    end
    for (int i = 0; i < IMG_PIX; i++) begin
      beat(1'b1, 2'b01, (lineIdx * 37 + i * 23 + i * i) % 256, first, first && fs);
      first = 1'b0;
      gapMaybe();
    end
    for (int j = 0; j < nDark; j++) begin
      beat(1'b1, 2'b10, (darkBase + ((j == 0) ? darkBump : 0)) % 256, 1'b0, 1'b0);
      gapMaybe();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      expV[k] = 0; expD[k] = 0; expL[k] = 0; expF[k] = 0; expE[k] = 0;
      tagV[k] = "R9 reset"; tagD[k] = "R9 reset";
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    check(outValid == 1'b0, "R9 valid after reset", int'(outValid), 0);
    check(errSticky == 1'b0, "R9 error after reset", int'(errSticky), 0);
    check(outLineStart == 1'b0 && outFrameStart == 1'b0 && outLineEnd == 1'b0,
          "R9 markers after reset", 1, 0);
    rstN = 1'b1;

    defaultRef = 8'd30;
    sendLine(1'b1, 6, 0, DARK_PIX, 10, 6);    // R3 sum 126 rounds up to 11
    sendLine(1'b0, 6, 1, DARK_PIX, 200, 0);   // next level 200
    sendLine(1'b0, 6, 2, DARK_PIX, 0, 0);     // R5 floor at zero; next level 0
    sendLine(1'b0, 6, 3, DARK_PIX, 5, 5);     // R5 top saturation; sum 65 -> 5
    sendLine(1'b0, 6, 4, DARK_PIX - 1, 90, 0);// R6 short dark run
    sendLine(1'b0, 6, 5, DARK_PIX + 1, 90, 0);// R6 level held, long dark run
    sendLine(1'b0, 6, 6, DARK_PIX, 50, 11);   // level held again; sum 611 -> 51
    sendLine(1'b0, 0, 7, DARK_PIX, 3, 2);     // line start on an image beat
    defaultRef = 8'd100;
    sendLine(1'b1, 6, 8, DARK_PIX, 20, 4);    // R4 new frame uses default
    for (int l = 9; l < 27; l++) begin
      sendLine(l == 18, 6, l, DARK_PIX, (l * 53) % 200, l % 12);
    end
    // closing line start so the last dark run is judged, then drain
    beat(1'b1, 2'b00, 0, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) beat(1'b0, 2'b00, 0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule